// File: doc/BRIEF.md
# ADC Conversion Controller with Interrupt Reporting

This block is the device-side register interface for one multiplexed 12-bit analog input. A host reaches it over a 16-bit word bus with byte addressing. The host writes a command word that holds the input mode, the channel and the range code. The same write may set a start bit. A started conversion keeps the block busy for a fixed, parameterised number of clock cycles. At the end of that time the block captures a sample from a parallel test port, stores it left-justified in a result word, and raises a ready bit in a shared interrupt status register.

The host may poll the busy bit. It may also enable the ready source and wait for the interrupt request. It then clears the ready bit by writing a one to it. The decoded multiplexer channel, the mode and the range bits are driven out to the analog front end. In differential mode the channel field moves up by one bit position.

Top module: `adc_conv_ctrl`

## Requirements
- R1: After reset, every register reads 0x0000 and irq_o is low.
- R2: A write to offset 0x00 with bit 0 set starts a conversion when the block is idle. Bit 0 of offset 0x00 then reads 1 for exactly CONV_CYCLES clock cycles, counted from the write edge.
- R3: Bits 11:8, bit 6 and bits 5:4 of offset 0x00 read back as last written. All other bits except bit 0 read 0. Bit 5 drives span10_o and bit 4 drives bipolar_o, with range codes 0x00, 0x20, 0x10 and 0x30 for 0-5 V, 0-10 V, +/-5 V and +/-10 V.
- R4: When bit 6 (differential) is 0, mux_sel_o is bits 11:8, giving channels 0 to 15. When bit 6 is 1, mux_sel_o is bits 11:9 zero-extended, giving channels 0 to 7, and bit 8 is ignored.
- R5: When a conversion ends, sample_i is captured. Offset 0x02 then returns it in bits 15:4, with bits 3:0 reading 0. The value holds until the next conversion ends.
- R6: The end of a conversion sets bit 0 of the status register at offset 0x0E. This happens on the same edge at which busy falls.
- R7: Writing 1 to a bit of offset 0x0E clears that bit, and writing 0 leaves it set. Writing 0x00FF clears every source.
- R8: The enable register at offset 0x0C holds 8 bits. irq_o is high exactly when some status bit and its matching enable bit are both set.
- R9: A start request that arrives while a conversion is busy is ignored. The running conversion still ends at its original edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_we_i | input | 1 | Write strobe, one cycle per write |
| bus_addr_i | input | 5 | Byte address of the 16-bit register |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for bus_addr_i (combinational) |
| sample_i | input | 12 | Parallel test sample standing in for the converter |
| mux_sel_o | output | 4 | Decoded input multiplexer channel |
| diff_o | output | 1 | Differential mode |
| bipolar_o | output | 1 | Bipolar range |
| span10_o | output | 1 | 10 V span selected |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with CONV_CYCLES set to 4. With this value the busy bit can be polled on every cycle, and the exact length of busy can be counted. A second start can also be issued in the middle of a conversion, with time left to see that the end edge does not move. The default of 16 keeps the counter width derivation under test only at elaboration.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned NUM_SRC = 8;
  localparam logic [ADDR_W-1:0] OFS_CMD  = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_RES  = 5'h02;
  localparam logic [ADDR_W-1:0] OFS_IEN  = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_STAT = 5'h0E;
  localparam int unsigned SRC_READY = 0;
endpackage

// File: rtl/adc_cmd_regs.sv
module adc_cmd_regs
  import adc_ctrl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              busy_i,
  output logic [3:0]        chan_raw_o,
  output logic              diff_o,
  output logic [1:0]        range_o,
  output logic [NUM_SRC-1:0] ien_o,
  output logic              start_o,
  output logic [3:0]        mux_sel_o
);
  logic cmd_wr, ien_wr;
  assign cmd_wr = we_i && (addr_i == OFS_CMD);
  assign ien_wr = we_i && (addr_i == OFS_IEN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chan_raw_o <= '0;
      diff_o     <= 1'b0;
      range_o    <= '0;
      ien_o      <= '0;
    end else begin
      if (cmd_wr) begin
        chan_raw_o <= wdata_i[11:8];
        diff_o     <= wdata_i[6];
        range_o    <= wdata_i[5:4];
      end
      if (ien_wr) ien_o <= wdata_i[NUM_SRC-1:0];
    end
  end

  // start only accepted from idle
  assign start_o = cmd_wr && wdata_i[0] && !busy_i;

  // differential mode takes the channel one bit higher
  assign mux_sel_o = diff_o ? {1'b0, chan_raw_o[3:1]} : chan_raw_o;
endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
  parameter int unsigned CONV_CYCLES = 16,
  parameter int unsigned RES_W       = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [RES_W-1:0] sample_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [RES_W-1:0] result_o
);
  localparam int unsigned CNT_W = $clog2(CONV_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(CONV_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  assign done_o = busy_o && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o   <= 1'b0;
      cnt_q    <= '0;
      result_o <= '0;
    end else if (done_o) begin
      busy_o   <= 1'b0;
      result_o <= sample_i;
    end else if (busy_o) begin
      cnt_q <= cnt_q - 1'b1;
    end else if (start_i) begin
      busy_o <= 1'b1;
      cnt_q  <= CNT_LOAD;
    end
  end
endmodule

// File: rtl/adc_irq_unit.sv
module adc_irq_unit
  import adc_ctrl_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic [NUM_SRC-1:0] ien_i,
  output logic [NUM_SRC-1:0] stat_o,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] clr;
  assign clr = (we_i && (addr_i == OFS_STAT)) ? wdata_i[NUM_SRC-1:0] : '0;

  // a new event wins over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_o <= '0;
    else         stat_o <= (stat_o & ~clr) | set_i;
  end

  assign irq_o = |(stat_o & ien_i);
endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl
  import adc_ctrl_pkg::*;
#(
  parameter int unsigned CONV_CYCLES = 16,
  parameter int unsigned RES_W       = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic [RES_W-1:0]  sample_i,
  output logic [3:0]        mux_sel_o,
  output logic              diff_o,
  output logic              bipolar_o,
  output logic              span10_o,
  output logic              irq_o
);
  logic [3:0]         chan_raw;
  logic [1:0]         range_code;
  logic [NUM_SRC-1:0] irq_en, irq_stat, irq_set;
  logic               start, busy, done;
  logic [RES_W-1:0]   result;

  adc_cmd_regs i_cmd (
    .clk_i, .rst_ni,
    .we_i(bus_we_i), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
    .busy_i(busy),
    .chan_raw_o(chan_raw), .diff_o(diff_o), .range_o(range_code),
    .ien_o(irq_en), .start_o(start), .mux_sel_o(mux_sel_o)
  );

  adc_conv_timer #(.CONV_CYCLES(CONV_CYCLES), .RES_W(RES_W)) i_timer (
    .clk_i, .rst_ni,
    .start_i(start), .sample_i(sample_i),
    .busy_o(busy), .done_o(done), .result_o(result)
  );

  always_comb begin
    irq_set            = '0;
    irq_set[SRC_READY] = done;
  end

  adc_irq_unit i_irq (
    .clk_i, .rst_ni,
    .we_i(bus_we_i), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
    .set_i(irq_set), .ien_i(irq_en),
    .stat_o(irq_stat), .irq_o(irq_o)
  );

  assign bipolar_o = range_code[0];
  assign span10_o  = range_code[1];

  always_comb begin
    bus_rdata_o = '0;
    unique case (bus_addr_i)
      OFS_CMD:  bus_rdata_o = {4'b0, chan_raw, 1'b0, diff_o, range_code, 3'b0, busy};
      OFS_RES:  bus_rdata_o = {result, {(DATA_W-RES_W){1'b0}}};
      OFS_IEN:  bus_rdata_o[NUM_SRC-1:0] = irq_en;
      OFS_STAT: bus_rdata_o[NUM_SRC-1:0] = irq_stat;
      default:  bus_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/adc_conv_ctrl_chk.sv
module adc_conv_ctrl_chk
  import adc_ctrl_pkg::*;
#(
  parameter int unsigned CONV_CYCLES = 16,
  parameter int unsigned RES_W       = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [DATA_W-1:0] bus_wdata_i,
  input logic              busy,
  input logic              stat_rdy,
  input logic              ien_rdy,
  input logic [RES_W-1:0]  result,
  input logic              irq_o
);
  logic [15:0] busy_len_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   busy_len_q <= '0;
    else if (busy) busy_len_q <= busy_len_q + 1'b1;
    else           busy_len_q <= '0;
  end

  // R2
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == OFS_CMD && bus_wdata_i[0] && !busy) |=> busy);
  // R2
  busy_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> (busy_len_q == 16'(CONV_CYCLES)));
  // R6
  ready_on_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_rdy) |-> $fell(busy));
  // R5
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(result) |-> $fell(busy));
  // R8
  irq_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ien_rdy) |-> !irq_o);
endmodule

bind adc_conv_ctrl adc_conv_ctrl_chk #(.CONV_CYCLES(CONV_CYCLES), .RES_W(RES_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i),
  .bus_wdata_i(bus_wdata_i), .busy(busy), .stat_rdy(irq_stat[0]),
  .ien_rdy(irq_en[0]), .result(result), .irq_o(irq_o)
);

// File: tb/test_adc_conv_ctrl.sv
module test_adc_conv_ctrl;
  localparam int unsigned CONV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [11:0] sample = '0;
  logic [3:0]  mux_sel;
  logic        diff, bip, span10, irq;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  adc_conv_ctrl #(.CONV_CYCLES(CONV), .RES_W(12)) i_adc_conv_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .sample_i(sample),
    .mux_sel_o(mux_sel), .diff_o(diff), .bipolar_o(bip), .span10_o(span10),
    .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  // after a start write, count consecutive busy samples, one per cycle
  task automatic count_busy(output int n);
    logic [15:0] v;
    n = 0;
    rd(5'h00, v);
    while (v[0] && n < 100) begin
      n++;
      @(negedge clk);
      rd(5'h00, v);
    end
  endtask

  task automatic t_reset;
    logic [15:0] v;
    rd(5'h00, v); chk("R1 cmd", v, 16'h0000);
    rd(5'h02, v); chk("R1 result", v, 16'h0000);
    rd(5'h0C, v); chk("R1 enable", v, 16'h0000);
    rd(5'h0E, v); chk("R1 status", v, 16'h0000);
    chk("R1 irq", {15'b0, irq}, 16'h0000);
  endtask

  task automatic t_config;
    logic [15:0] v;
    wr(5'h00, 16'hFD3E);                // chan 13, +/-10 V, stray bits set
    rd(5'h00, v); chk("R3 readback", v, 16'h0D30);
    chk("R4 se mux", {12'b0, mux_sel}, 16'd13);
    chk("R3 range pins", {14'b0, span10, bip}, 16'h0003);
    wr(5'h00, 16'h0020);                // chan 0, 0-10 V
    chk("R3 span only", {14'b0, span10, bip}, 16'h0002);
    wr(5'h00, 16'h0A50);                // diff chan 5, +/-5 V
    rd(5'h00, v); chk("R3 diff readback", v, 16'h0A50);
    chk("R4 diff mux", {12'b0, mux_sel}, 16'd5);
    wr(5'h00, 16'h0B40);                // bit 8 ignored in diff
    chk("R4 diff bit8", {11'b0, diff, mux_sel}, 16'h0015);
  endtask

  task automatic t_convert;
    logic [15:0] v;
    int n;
    sample = 12'hABC;
    wr(5'h00, 16'h0301);
    count_busy(n);
    chk("R2 busy length", 16'(n), 16'(CONV));
    rd(5'h02, v); chk("R5 result", v, 16'hABC0);
    rd(5'h0E, v); chk("R6 status set", v, 16'h0001);
    chk("R8 irq masked", {15'b0, irq}, 16'h0000);
    sample = 12'h123;
    repeat (3) @(negedge clk);
    rd(5'h02, v); chk("R5 result held", v, 16'hABC0);
  endtask

  task automatic t_irq;
    logic [15:0] v;
    wr(5'h0C, 16'h00A5);
    rd(5'h0C, v); chk("R8 enable readback", v, 16'h00A5);
    chk("R8 irq on", {15'b0, irq}, 16'h0001);
    wr(5'h0E, 16'h00FE);
    rd(5'h0E, v); chk("R7 write zero keeps", v, 16'h0001);
    wr(5'h0E, 16'h0001);
    rd(5'h0E, v); chk("R7 w1c", v, 16'h0000);
    chk("R8 irq off", {15'b0, irq}, 16'h0000);
  endtask

  task automatic t_restart_ignored;
    logic [15:0] v;
    int n;
    sample = 12'h5A5;
    wr(5'h00, 16'h0001);               // first start; one cycle already spent
    wr(5'h00, 16'h0001);               // second start while busy
    count_busy(n);
    chk("R9 no restart", 16'(n), 16'(CONV - 2));
    rd(5'h02, v); chk("R9 result", v, 16'h5A50);
    chk("R8 irq after conv", {15'b0, irq}, 16'h0001);
    wr(5'h0E, 16'h00FF);
    rd(5'h0E, v); chk("R7 clear all", v, 16'h0000);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_config();
    t_convert();
    t_irq();
    t_restart_ignored();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule